// File: doc/BRIEF.md
# Timing Mode Switch Controller

This block owns the control bits that choose how a network-side line interface takes its timing: from a fixed external reference, or from an adaptive recovery loop built elsewhere. A host writes a small control word. The block keeps the mode in fixed timing until it sees a legal entry order. That order is: the data-recovery enable bit is already set, and then the mode request bit is written. After the request it waits for a settling period, counted in millisecond ticks. Only after that wait does it report that the recovery control bits may be driven freely.

Leaving adaptive timing takes one write with the mode request bit cleared. The same write, made during the settling wait, cancels the wait at once. While the wait runs, writes to the two recovery control bits are held off. The read-back word shows the mode request, both control bits and a read-only ready bit.

Top module: `timing_mode_ctrl`

## Requirements
- R1: After reset the read-back word is 0 and the fixed mode is in force. `adaptive_mode` and `ready` are both low.
- R2: Write word layout is bit 0 = rate-adjust control, bit 1 = data-recovery enable, bit 2 = mode request. Read-back word is bit 0 = rate-adjust, bit 1 = data-recovery, bit 2 = mode request, bit 3 = ready. In fixed mode, a write stores bits 0 and 1 as given.
- R3: In fixed mode, a write with bit 2 set is accepted only if the stored data-recovery bit is already 1 before that write. An accepted write starts the settling wait, and `adaptive_mode` is high from the next cycle.
- R4: A mode request made while the stored data-recovery bit is 0 is ignored. The block stays in fixed mode, and bits 0 and 1 of that write are stored.
- R5: The settling wait ends on the cycle in which the SETTLE_TICKS-th (default 100) `tick_ms` pulse since entry arrives. `ready` is high from the next cycle. A tick in the entry cycle itself, or while the block is in fixed mode, is not counted.
- R6: Writes made during the settling wait do not change the two control bits. This includes the write that starts the wait.
- R7: A write with bit 2 clear during the settling wait returns the block to fixed mode on the next cycle. A later entry counts a full new wait.
- R8: Once `ready` is high, writes with bit 2 set store bits 0 and 1. A write with bit 2 clear stores bits 0 and 1 and returns the block to fixed mode.
- R9: When a cancelling write and the terminal tick fall in the same cycle, the cancel wins and the block goes to fixed mode.
- R10: `ready` is never high while the mode request bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 3 | Write word (rate-adjust, data-recovery, mode request) |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rd_data | output | 4 | Read-back word, ready bit in bit 3 |
| adaptive_mode | output | 1 | High while the adaptive mode is requested and accepted |
| ready | output | 1 | High when the settling wait is complete |

## Verification
Two events can land in the same cycle: the terminal settling tick, and a host write to the control word. The bench counts the wait down to its last tick. It then sends that tick together with a write that clears the mode request, which must give fixed mode. In a separate run it sends the tick together with a write that keeps the request set but changes both control bits. That must give ready with the control bits untouched. A behavioural model updated on every clock decides each expected value.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int unsigned BIT_RATE  = 0;
    localparam int unsigned BIT_RECOV = 1;
    localparam int unsigned BIT_REQ   = 2;
    localparam int unsigned BIT_READY = 3;
    localparam int unsigned WR_W      = 3;
    localparam int unsigned RD_W      = 4;

    typedef enum logic [1:0] {
        TM_FIXED  = 2'd0,
        TM_SETTLE = 2'd1,
        TM_RUN    = 2'd2
    } tm_state_e;

    typedef struct packed {
        logic recov;
        logic rate;
    } tm_ctl_t;

endpackage

// File: rtl/tmc_settle_timer.sv
module tmc_settle_timer #(
    parameter int unsigned SETTLE_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_last;

    always_comb begin
        tmr_d   = tmr_q;
        at_last = (tmr_q.cnt == LAST);
        done_o  = run_i && tick_i && at_last;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tick_i) begin
            tmr_d.cnt = at_last ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // a stopped timer always restarts from zero
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tmr_q.cnt == '0)) else $error("timer not cleared"); // R7

endmodule

// File: rtl/tmc_seq_fsm.sv
module tmc_seq_fsm
    import tmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_i,
    input  logic      wr_req_i,
    input  logic      recov_q_i,
    input  logic      done_i,
    output tm_state_e state_o,
    output logic      ctl_we_o
);
    typedef struct packed {
        tm_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic cancel;
    logic enter;

    always_comb begin
        fsm_d    = fsm_q;
        cancel   = wr_en_i && !wr_req_i;
        enter    = wr_en_i && wr_req_i && recov_q_i;
        ctl_we_o = 1'b0;
        unique case (fsm_q.st)
            TM_FIXED: begin
                if (enter) fsm_d.st = TM_SETTLE;
                else       ctl_we_o = wr_en_i;
            end
            TM_SETTLE: begin
                if (cancel)      fsm_d.st = TM_FIXED;
                else if (done_i) fsm_d.st = TM_RUN;
            end
            TM_RUN: begin
                ctl_we_o = wr_en_i;
                if (cancel) fsm_d.st = TM_FIXED;
            end
            default: fsm_d.st = TM_FIXED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: TM_FIXED};
        else        fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.st;

    AST_REQ_NEEDS_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TM_FIXED && wr_en_i && wr_req_i && !recov_q_i)
        |=> (fsm_q.st == TM_FIXED)) else $error("request accepted without recovery bit"); // R4
    AST_CANCEL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != TM_FIXED && wr_en_i && !wr_req_i)
        |=> (fsm_q.st == TM_FIXED)) else $error("cancel ignored"); // R7
    AST_RUN_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TM_FIXED) |=> (fsm_q.st != TM_RUN)) else $error("skipped settling"); // R3

endmodule

// File: rtl/tmc_ctl_reg.sv
module tmc_ctl_reg
    import tmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    we_i,
    input  tm_ctl_t wdata_i,
    output tm_ctl_t ctl_o
);
    tm_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we_i) ctl_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/timing_mode_ctrl.sv
module timing_mode_ctrl
    import tmc_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            tick_ms,
    output logic [RD_W-1:0] rd_data,
    output logic            adaptive_mode,
    output logic            ready
);
    tm_state_e state;
    tm_ctl_t   ctl;
    tm_ctl_t   wctl;
    logic      ctl_we;
    logic      settle_done;
    logic      settling;

    assign wctl.rate  = wr_data[BIT_RATE];
    assign wctl.recov = wr_data[BIT_RECOV];
    assign settling   = (state == TM_SETTLE);

    tmc_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_req_i (wr_data[BIT_REQ]),
        .recov_q_i(ctl.recov),
        .done_i   (settle_done),
        .state_o  (state),
        .ctl_we_o (ctl_we)
    );

    tmc_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (settling),
        .tick_i(tick_ms),
        .done_o(settle_done)
    );

    tmc_ctl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (ctl_we),
        .wdata_i(wctl),
        .ctl_o  (ctl)
    );

    always_comb begin
        adaptive_mode      = (state != TM_FIXED);
        ready              = (state == TM_RUN);
        rd_data            = '0;
        rd_data[BIT_RATE]  = ctl.rate;
        rd_data[BIT_RECOV] = ctl.recov;
        rd_data[BIT_REQ]   = adaptive_mode;
        rd_data[BIT_READY] = ready;
    end

    AST_HOLD_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (settling && wr_en) |=> $stable(ctl)) else $error("control bits written while settling"); // R6
    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick_ms)) else $error("ready without tick"); // R5
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> rd_data[BIT_REQ]) else $error("ready without request"); // R10

endmodule

// File: tb/test_timing_mode_ctrl.sv
module test_timing_mode_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TICKS = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic       tick_ms = 1'b0;
    logic [3:0] rd_data;
    logic       adaptive_mode;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int m_state = 0;   // 0 fixed, 1 settling, 2 ready
    int m_cnt = 0;
    bit m_rate = 0;
    bit m_recov = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timing_mode_ctrl #(.SETTLE_TICKS(TICKS)) i_timing_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick_ms(tick_ms), .rd_data(rd_data),
        .adaptive_mode(adaptive_mode), .ready(ready)
    );

    task automatic model(input bit we, input bit [2:0] d, input bit tk);
        if (we && m_state == 0) begin
            if (d[2] && m_recov) begin m_state = 1; m_cnt = 0; end
            else begin m_rate = d[0]; m_recov = d[1]; end
        end else if (m_state == 1) begin
            if (we && !d[2]) begin m_state = 0; m_cnt = 0; end
            else if (tk) begin
                m_cnt++;
                if (m_cnt == TICKS) begin m_state = 2; m_cnt = 0; end
            end
        end else if (m_state == 2 && we) begin
            m_rate = d[0]; m_recov = d[1];
            if (!d[2]) m_state = 0;
        end
    endtask

    task automatic compare(input string req);
        logic [3:0] exp_rd;
        exp_rd = {m_state == 2, m_state != 0, m_recov, m_rate};
        checks++;
        if (rd_data !== exp_rd || adaptive_mode !== (m_state != 0) || ready !== (m_state == 2)) begin
            errors++;
            $display("FAIL %s: rd=%b mode=%b ready=%b expected rd=%b mode=%b ready=%b",
                     req, rd_data, adaptive_mode, ready, exp_rd, m_state != 0, m_state == 2);
        end
    endtask

    task automatic step(input bit we, input bit [2:0] d, input bit tk, input string req);
        wr_en = we; wr_data = d; tick_ms = tk;
        @(posedge clk);
        model(we, d, tk);
        @(negedge clk);
        wr_en = 1'b0; tick_ms = 1'b0;
        compare(req);
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 3'b000, 1'b1, req);
            if (i % 7 == 3) step(1'b0, 3'b000, 1'b0, req);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        // R4: request with recovery bit still 0, same write sets it
        step(1'b1, 3'b110, 1'b0, "R4");
        step(1'b1, 3'b001, 1'b0, "R2");
        step(1'b1, 3'b011, 1'b1, "R2");
        // R3: legal entry; R6: entry write's control bits are not stored
        step(1'b1, 3'b100, 1'b1, "R3");
        ticks(40, "R5");
        step(1'b1, 3'b100, 1'b0, "R6");
        step(1'b1, 3'b111, 1'b1, "R6");
        ticks(10, "R5");
        // R7: cancel mid-wait, then a fresh full wait
        step(1'b1, 3'b011, 1'b0, "R7");
        step(1'b0, 3'b000, 1'b1, "R7");
        step(1'b1, 3'b111, 1'b0, "R3");
        ticks(TICKS - 1, "R5");
        step(1'b0, 3'b000, 1'b0, "R5");
        step(1'b0, 3'b000, 1'b1, "R5");
        step(1'b0, 3'b000, 1'b1, "R10");
        // R8: free use of control bits once ready
        step(1'b1, 3'b100, 1'b0, "R8");
        step(1'b1, 3'b101, 1'b1, "R8");
        step(1'b1, 3'b011, 1'b0, "R8");
        step(1'b1, 3'b010, 1'b0, "R8");
        // R9: cancel together with the terminal tick
        step(1'b1, 3'b110, 1'b0, "R3");
        ticks(TICKS - 1, "R9");
        step(1'b1, 3'b000, 1'b1, "R9");
        step(1'b0, 3'b000, 1'b0, "R9");
        // R6/R9: request kept set together with terminal tick
        step(1'b1, 3'b100, 1'b0, "R3");
        ticks(TICKS - 1, "R6");
        step(1'b1, 3'b101, 1'b1, "R6");
        step(1'b0, 3'b000, 1'b0, "R10");
        // R1: reset mid-operation
        rst_n = 1'b0;
        m_state = 0; m_cnt = 0; m_rate = 0; m_recov = 0;
        @(negedge clk);
        compare("R1");
        finish_run();
    end
endmodule